// File: doc/BRIEF.md
# SD Host Power-Control Handshake Unit

This unit sits between the power-sequencing logic of an SD host controller and the software that owns the board regulators. It is a small bank of registers. When the core logic needs bus power switched on or off, or the I/O signalling level moved low or high, it pulses one of four request inputs. The pulse sets a sticky status bit. The status bits, gated by a mask register, drive a single level interrupt.

Software reads the status, clears the bits it has taken by writing ones to a clear register, and does the regulator work. It then writes a result code to an acknowledge register. One result pair covers the bus-power channel and one covers the I/O-level channel. The unit closes the request on each channel that was waiting. It gives the core a one-cycle done pulse and a fail flag for that channel.

The bus-power channel admits only one outstanding request. Later bus requests are dropped until software answers. The I/O channel has no such hold-off.

Top module: `sdpwr_handshake`

## Requirements
- R1: After a synchronous reset, every register reads zero, irq is low, and the done and fail outputs of both channels are low.
- R2: A request pulse sets its status bit (bit 0 bus off, bit 1 bus on, bit 2 I/O low, bit 3 I/O high) on the next clock edge. The bit stays set until it is cleared. Status is read at byte offset 0xDC.
- R3: Writing to the clear register at 0xE4 clears exactly the status bits written as one and leaves the others. The clear register reads as zero.
- R4: If a request pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R5: irq is high exactly when some status bit and the same bit of the mask register (offset 0xE0, bits 3:0) are both one. The mask reads back as written.
- R6: After a bus request is accepted and until a bus result is written, bus-off and bus-on pulses leave the status register unchanged.
- R7: A write to the acknowledge register at 0xE8 closes each waiting channel whose result bits are nonzero. The bus channel uses bit 0 for success and bit 1 for failure. The I/O channel uses bit 2 for success and bit 3 for failure. The closed channel's done output is high for exactly the cycle after the write. Its fail output then holds the failure bit until the next close. Both channels can close in one write.
- R8: The acknowledge register reads back the last four bits written to it.
- R9: Bits 31:4 of every register read as zero, and writes to them have no effect. Writes to the status register have no effect. Reads at unmapped offsets return zero.
- R10: A result written for a channel with no waiting request gives no done pulse.
- R11: I/O requests are never held off. A second I/O pulse while an I/O request waits still sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| req_bus_off | input | 1 | Pulse: bus power off wanted |
| req_bus_on | input | 1 | Pulse: bus power on wanted |
| req_io_low | input | 1 | Pulse: low I/O level wanted |
| req_io_high | input | 1 | Pulse: high I/O level wanted |
| irq | output | 1 | Level interrupt to software |
| bus_done | output | 1 | One-cycle pulse when the bus request is answered |
| bus_fail | output | 1 | Failure result of the last bus answer |
| io_done | output | 1 | One-cycle pulse when the I/O request is answered |
| io_fail | output | 1 | Failure result of the last I/O answer |

## Verification
Two pairs of events can collide in one cycle. A request pulse can meet a software clear of the same status bit. A bus answer and an I/O answer can arrive in a single acknowledge write. The bench drives the pulse and the clear write on the same edge and expects the bit to read back as set. It also writes a combined result while both channels are waiting and expects both done pulses in the same cycle, each with its own fail value. The bench also sends bus pulses while the bus channel is waiting and checks that the status register does not change.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;

    localparam int NREQ  = 4;   // request sources
    localparam int NCHAN = 2;   // answer channels: 0 bus power, 1 I/O level

    // status bit order is decoded by software: keep it fixed
    typedef struct packed {
        logic io_high;   // bit 3
        logic io_low;    // bit 2
        logic bus_on;    // bit 1
        logic bus_off;   // bit 0
    } req_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STS,
        SEL_MASK,
        SEL_ACK
    } rd_sel_t;

    localparam logic [11:0] OFS_STS  = 12'h0DC;
    localparam logic [11:0] OFS_MASK = 12'h0E0;
    localparam logic [11:0] OFS_CLR  = 12'h0E4;
    localparam logic [11:0] OFS_ACK  = 12'h0E8;

    function automatic logic addr_hit(input logic [11:0] a, input logic [11:0] ofs);
        return a == ofs;
    endfunction

endpackage

// File: rtl/sdpwr_status.sv
module sdpwr_status
    import sdpwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] acc_req,
    input  logic            clr_wr,
    input  logic [NREQ-1:0] clr_bits,
    input  logic            mask_wr,
    input  logic [NREQ-1:0] mask_bits,
    output logic [NREQ-1:0] sts_q,
    output logic [NREQ-1:0] mask_q,
    output logic            irq
);

    logic [NREQ-1:0] clr_eff;
    logic [NREQ-1:0] sts_d;

    always_comb begin
        clr_eff = clr_wr ? clr_bits : '0;
        // an arriving request beats a clear of the same bit
        sts_d   = (sts_q & ~clr_eff) | acc_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            mask_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (mask_wr)
                mask_q <= mask_bits;
        end
    end

    assign irq = |(sts_q & mask_q);

    p_req_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(acc_req)) == $past(acc_req)));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & $past(clr_eff & ~acc_req)) == '0));

endmodule

// File: rtl/sdpwr_ack_chan.sv
module sdpwr_ack_chan #(
    parameter bit HOLD_OFF = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req_raw,
    input  logic       ack_wr,
    input  logic       ack_ok,
    input  logic       ack_bad,
    output logic [1:0] req_acc,
    output logic       pend_q,
    output logic       done_q,
    output logic       fail_q
);

    logic release_now;

    generate
        if (HOLD_OFF) begin : g_hold
            assign req_acc = pend_q ? 2'b00 : req_raw;
        end else begin : g_free
            assign req_acc = req_raw;
        end
    endgenerate

    assign release_now = ack_wr && (ack_ok || ack_bad) && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (|req_acc)
                pend_q <= 1'b1;
            else if (release_now)
                pend_q <= 1'b0;
            done_q <= release_now;
            if (release_now)
                fail_q <= ack_bad;
        end
    end

    p_done_needs_pend_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(pend_q));

    p_fail_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(fail_q));

endmodule

// File: rtl/sdpwr_handshake.sv
module sdpwr_handshake
    import sdpwr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_bus_off,
    input  logic              req_bus_on,
    input  logic              req_io_low,
    input  logic              req_io_high,
    output logic              irq,
    output logic              bus_done,
    output logic              bus_fail,
    output logic              io_done,
    output logic              io_fail
);

    localparam int PAD_W = DATA_W - NREQ;

    req_vec_t        req_raw;
    logic [NREQ-1:0] req_acc;
    logic [NREQ-1:0] sts_q, mask_q;
    logic [NREQ-1:0] ack_q;
    logic [NCHAN-1:0] pend, done, fail;
    logic [11:0]     a12;
    logic            wr_mask, wr_clr, wr_ack;
    rd_sel_t         rsel;
    logic [NREQ-1:0] rd_nib;

    assign req_raw = '{io_high: req_io_high, io_low: req_io_low,
                       bus_on: req_bus_on, bus_off: req_bus_off};
    assign a12     = 12'(reg_addr);

    assign wr_mask = reg_wr && addr_hit(a12, OFS_MASK);
    assign wr_clr  = reg_wr && addr_hit(a12, OFS_CLR);
    assign wr_ack  = reg_wr && addr_hit(a12, OFS_ACK);

    always_comb begin
        if (addr_hit(a12, OFS_STS))       rsel = SEL_STS;
        else if (addr_hit(a12, OFS_MASK)) rsel = SEL_MASK;
        else if (addr_hit(a12, OFS_ACK))  rsel = SEL_ACK;
        else                              rsel = SEL_NONE;
        unique case (rsel)
            SEL_STS:  rd_nib = sts_q;
            SEL_MASK: rd_nib = mask_q;
            SEL_ACK:  rd_nib = ack_q;
            default:  rd_nib = '0;
        endcase
    end

    assign reg_rdata = {{PAD_W{1'b0}}, rd_nib};

    always_ff @(posedge clk) begin
        if (rst)
            ack_q <= '0;
        else if (wr_ack)
            ack_q <= reg_wdata[NREQ-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < NCHAN; g++) begin : g_chan
            sdpwr_ack_chan #(.HOLD_OFF(g == 0)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .req_raw (req_raw[2*g+1 -: 2]),
                .ack_wr  (wr_ack),
                .ack_ok  (reg_wdata[2*g]),
                .ack_bad (reg_wdata[2*g+1]),
                .req_acc (req_acc[2*g+1 -: 2]),
                .pend_q  (pend[g]),
                .done_q  (done[g]),
                .fail_q  (fail[g])
            );
        end
    endgenerate

    sdpwr_status u_status (
        .clk       (clk),
        .rst       (rst),
        .acc_req   (req_acc),
        .clr_wr    (wr_clr),
        .clr_bits  (reg_wdata[NREQ-1:0]),
        .mask_wr   (wr_mask),
        .mask_bits (reg_wdata[NREQ-1:0]),
        .sts_q     (sts_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    assign bus_done = done[0];
    assign bus_fail = fail[0];
    assign io_done  = done[1];
    assign io_fail  = fail[1];

    p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
        pend[0] |=> ((sts_q[1:0] & ~$past(sts_q[1:0])) == 2'b00));

    p_rd_pad_r9: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:NREQ] == '0);

endmodule

// File: tb/sdpwr_handshake_tb.sv
module sdpwr_handshake_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        r_boff, r_bon, r_iol, r_ioh;
    logic        irq, bus_done, bus_fail, io_done, io_fail;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdpwr_handshake u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_bus_off(r_boff), .req_bus_on(r_bon),
        .req_io_low(r_iol), .req_io_high(r_ioh),
        .irq(irq), .bus_done(bus_done), .bus_fail(bus_fail),
        .io_done(io_done), .io_fail(io_fail)
    );

    localparam logic [11:0] A_STS = 12'hDC, A_MASK = 12'hE0,
                            A_CLR = 12'hE4, A_ACK = 12'hE8;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] r);
        {r_ioh, r_iol, r_bon, r_boff} = r;
        @(negedge clk);
        {r_ioh, r_iol, r_bon, r_boff} = 4'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 status", A_STS, 0);
        rd_chk("R1 mask", A_MASK, 0);
        rd_chk("R1 ack", A_ACK, 0);
        chk("R1 outputs", {irq, bus_done, bus_fail, io_done, io_fail}, 0);
    endtask

    task automatic t_sticky_mask;
        pulse(4'b0100);
        rd_chk("R2 io_low sets bit2", A_STS, 32'h4);
        @(negedge clk);
        rd_chk("R2 bit2 stays", A_STS, 32'h4);
        chk("R5 irq masked off", irq, 0);
        wr(A_MASK, 32'hFFFF_FFF1);
        rd_chk("R9 mask upper bits dropped", A_MASK, 32'h1);
        chk("R5 irq off, bit2 unmasked", irq, 0);
        wr(A_MASK, 32'hF);
        chk("R5 irq on", irq, 1);
        wr(A_STS, 32'hF);
        rd_chk("R9 status write ignored", A_STS, 32'h4);
        rd_chk("R9 unmapped reads zero", 12'h000, 0);
    endtask

    task automatic t_clear;
        pulse(4'b1000);
        rd_chk("R11 io_high accepted while io waits", A_STS, 32'hC);
        wr(A_CLR, 32'h8);
        rd_chk("R3 clears only bit3", A_STS, 32'h4);
        rd_chk("R3 clear reads zero", A_CLR, 0);
        wr(A_CLR, 32'h4);
        rd_chk("R3 all clear", A_STS, 0);
        chk("R5 irq drops", irq, 0);
    endtask

    task automatic t_race;
        pulse(4'b0100);
        // clear and request of bit2 on the same edge
        reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h4; r_iol = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; r_iol = 1'b0;
        rd_chk("R4 request wins over clear", A_STS, 32'h4);
        wr(A_CLR, 32'h4);
        wr(A_ACK, 32'h4);
        chk("R7 io_done pulse", io_done, 1);
        chk("R7 io_fail low", io_fail, 0);
        chk("R10 bus idle no done", bus_done, 0);
        @(negedge clk);
        chk("R7 io_done one cycle", io_done, 0);
    endtask

    task automatic t_bus;
        pulse(4'b0010);
        rd_chk("R2 bus_on sets bit1", A_STS, 32'h2);
        pulse(4'b0001);
        rd_chk("R6 bus_off held off", A_STS, 32'h2);
        wr(A_CLR, 32'h2);
        pulse(4'b0010);
        rd_chk("R6 bus_on held off", A_STS, 0);
        wr(A_ACK, 32'hA);
        chk("R7 bus_done pulse", bus_done, 1);
        chk("R7 bus_fail high", bus_fail, 1);
        chk("R10 io not waiting", io_done, 0);
        rd_chk("R8 ack readback", A_ACK, 32'hA);
        @(negedge clk);
        chk("R7 bus_fail held", bus_fail, 1);
        pulse(4'b0001);
        rd_chk("R6 bus accepted after answer", A_STS, 32'h1);
        pulse(4'b1000);
        rd_chk("R2 both channels set", A_STS, 32'h9);
        wr(A_ACK, 32'hFFFF_FF05);
        chk("R7 both done bus", bus_done, 1);
        chk("R7 both done io", io_done, 1);
        chk("R7 both fail low", {bus_fail, io_fail}, 0);
        rd_chk("R8 R9 ack readback", A_ACK, 32'h5);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        {r_ioh, r_iol, r_bon, r_boff} = 4'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_sticky_mask;
        t_clear;
        t_race;
        t_bus;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule